// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 16-bit operands and a carry input without any clock. It returns a 16-bit sum and a carry output. The operand is cut into groups of bits. Every group above the lowest one prepares its result twice: once with a lookahead adder whose carry input is tied low, and once by incrementing that result. The carry that arrives from the group below then picks one of the two.

The default layout uses uneven groups of 2, 2, 3, 4 and 5 bits, counted from the least significant end. With this layout, the groups near the top have more time to finish before their select carry arrives. A parameter switches to four equal 4-bit groups, so the two layouts can be compared on the same logic. The lowest group takes the real carry input and has no select stage.

Top module: `sqrt_csel_add`

## Requirements
- R1: `sum_o` equals bits 15..0 of `a_i + b_i + cin_i` for every input combination, with no clock involved.
- R2: With `SQRT_MODE` = 1, the group boundaries sit at bit positions 2, 4, 7 and 11. A carry generated just below any of these boundaries reaches the bits above it.
- R3: With `SQRT_MODE` = 0, the group boundaries sit at bits 4, 8 and 12, and the arithmetic result is the same as in R1.
- R4: The lowest group uses `cin_i` directly. With both operands zero, `cin_i` = 1 gives `sum_o` = 1 and `cout_o` = 0.
- R5: The carry-in-one path wraps an all-ones group to all zeros and sets its carry. For example, 0xFFFF + 0 + 1 gives `sum_o` = 0 and `cout_o` = 1.
- R6: Each group's selected carry equals bit `hi+1` of the masked prefix sum `a_i[hi:0] + b_i[hi:0] + cin_i`, where `hi` is that group's top bit.
- R7: `cout_o` equals bit 16 of `a_i + b_i + cin_i`, and it is the carry selected by the most significant group.
- R8: The outputs settle within the same time step as an input change, because the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
Both layouts run side by side against a bench-computed reference. Directed vectors place a run of ones just below each group boundary and add one. This separates a correct select at that boundary from a mux that picks the wrong half or a carry wired to the wrong group. All-ones operands with carry-in test the incrementer wrap and the top carry. A carry-in with zero operands isolates the lowest group. Seeded random operands cover mixed propagate and generate patterns that the directed cases miss.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;
  localparam int ADD_W   = 16;
  localparam int MAX_GRP = 5;

  function automatic int num_grp(bit sqrt_mode);
    return sqrt_mode ? 5 : 4;
  endfunction

  function automatic int grp_w(bit sqrt_mode, int idx);
    if (!sqrt_mode) return ADD_W / 4;
    case (idx)
      0, 1:    return 2;
      2:       return 3;
      3:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int grp_lo(bit sqrt_mode, int idx);
    int lo;
    lo = 0;
    for (int j = 0; j < idx; j++) lo += grp_w(sqrt_mode, j);
    return lo;
  endfunction
endpackage

// File: rtl/csa_zcla.sv
`timescale 1ns/1ps
// Lookahead adder: each carry formed as a flat sum of generate/propagate products.
module csa_zcla #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  logic [W-1:0] p, g;
  logic [W:0]   c;

  assign p = a_i ^ b_i;
  assign g = a_i & b_i;

  always_comb begin
    c[0] = ci_i;
    for (int k = 1; k <= W; k++) begin
      logic acc;
      logic run;
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        run = g[j];
        for (int m = j + 1; m < k; m++) run = run & p[m];
        acc = acc | run;
      end
      run = ci_i;
      for (int m = 0; m < k; m++) run = run & p[m];
      c[k] = acc | run;
    end
  end

  assign sum_o = p ^ c[W-1:0];
  assign co_o  = c[W];
endmodule

// File: rtl/csa_excess1.sv
`timescale 1ns/1ps
// Adds one: bit k flips when all lower bits are one.
module csa_excess1 #(
  parameter int W = 4
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  always_comb begin
    logic low_ones;
    low_ones = 1'b1;
    for (int k = 0; k < W; k++) begin
      out_o[k] = in_i[k] ^ low_ones;
      low_ones = low_ones & in_i[k];
    end
  end
endmodule

// File: rtl/csa_sel_group.sv
`timescale 1ns/1ps
module csa_sel_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  logic [W-1:0] sum_z;
  logic         co_z;
  logic [W:0]   inc_out;

  csa_zcla #(.W(W)) u_zcla (
    .a_i  (a_i),
    .b_i  (b_i),
    .ci_i (1'b0),
    .sum_o(sum_z),
    .co_o (co_z)
  );

  csa_excess1 #(.W(W + 1)) u_inc (
    .in_i ({co_z, sum_z}),
    .out_o(inc_out)
  );

  assign sum_o = sel_i ? inc_out[W-1:0] : sum_z;
  assign co_o  = sel_i ? inc_out[W]     : co_z;
endmodule

// File: rtl/sqrt_csel_add.sv
`timescale 1ns/1ps
module sqrt_csel_add
  import csa_pkg::*;
#(
  parameter bit SQRT_MODE = 1'b1
) (
  input  logic [ADD_W-1:0] a_i,
  input  logic [ADD_W-1:0] b_i,
  input  logic             cin_i,
  output logic [ADD_W-1:0] sum_o,
  output logic             cout_o
);
  localparam int NG = num_grp(SQRT_MODE);

  logic [NG-1:0] grp_c;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    localparam int GW = grp_w(SQRT_MODE, gi);
    localparam int LO = grp_lo(SQRT_MODE, gi);
    if (gi == 0) begin : g_low
      csa_zcla #(.W(GW)) u_add (
        .a_i  (a_i[LO +: GW]),
        .b_i  (b_i[LO +: GW]),
        .ci_i (cin_i),
        .sum_o(sum_o[LO +: GW]),
        .co_o (grp_c[gi])
      );
    end else begin : g_sel
      csa_sel_group #(.W(GW)) u_grp (
        .a_i  (a_i[LO +: GW]),
        .b_i  (b_i[LO +: GW]),
        .sel_i(grp_c[gi-1]),
        .sum_o(sum_o[LO +: GW]),
        .co_o (grp_c[gi])
      );
    end
  end

  assign cout_o = grp_c[NG-1];
endmodule

// File: rtl/csa_checker.sv
`timescale 1ns/1ps
module csa_checker
  import csa_pkg::*;
#(
  parameter bit SQRT_MODE = 1'b1
) (
  input logic [ADD_W-1:0]                 a_i,
  input logic [ADD_W-1:0]                 b_i,
  input logic                             cin_i,
  input logic [ADD_W-1:0]                 sum_i,
  input logic                             cout_i,
  input logic [num_grp(SQRT_MODE)-1:0]    grp_c_i
);
  localparam int NG = num_grp(SQRT_MODE);

  always_comb begin
    logic [ADD_W:0] full;
    logic [ADD_W:0] low2;
    full = {1'b0, a_i} + {1'b0, b_i} + {{ADD_W{1'b0}}, cin_i};
    low2 = {15'd0, a_i[1:0]} + {15'd0, b_i[1:0]} + {{ADD_W{1'b0}}, cin_i};
    a_r1_sum_ok: assert (sum_i == full[ADD_W-1:0])
      else $error("R1 sum mismatch");
    a_r7_cout_ok: assert (cout_i == full[ADD_W] && cout_i == grp_c_i[NG-1])
      else $error("R7 carry mismatch");
    a_r4_low_group: assert (sum_i[1:0] == low2[1:0])
      else $error("R4 low group mismatch");
    for (int i = 0; i < NG; i++) begin
      logic [ADD_W:0] mask;
      logic [ADD_W:0] pre;
      int hi;
      hi   = grp_lo(SQRT_MODE, i) + grp_w(SQRT_MODE, i);
      mask = (17'd1 << hi) - 17'd1;
      pre  = ({1'b0, a_i} & mask) + ({1'b0, b_i} & mask) + {{ADD_W{1'b0}}, cin_i};
      a_r6_group_carry: assert (grp_c_i[i] == pre[hi])
        else $error("R6 group carry mismatch");
    end
  end
endmodule

bind sqrt_csel_add csa_checker #(.SQRT_MODE(SQRT_MODE)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_i  (sum_o),
  .cout_i (cout_o),
  .grp_c_i(grp_c)
);

// File: tb/tb_sqrt_csel_add.sv
`timescale 1ns/1ps
module tb_sqrt_csel_add;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum_s, sum_l;
  logic        co_s, co_l;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sqrt_csel_add #(.SQRT_MODE(1'b1)) dut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_s), .cout_o(co_s));
  sqrt_csel_add #(.SQRT_MODE(1'b0)) dut_lin (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_l), .cout_o(co_l));

  function automatic logic [16:0] ref_add(logic [15:0] x, logic [15:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  task automatic chk(string req, logic [16:0] got, logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%05h exp=%05h", req, got, exp);
    end
  endtask

  // Drive between edges; sample 2 ns later (combinational path, R8).
  task automatic run(logic [15:0] x, logic [15:0] y, logic c, string req);
    @(negedge clk);
    a = x; b = y; cin = c;
    #2;
    chk({req, " sqrt"},   {co_s, sum_s}, ref_add(x, y, c));
    chk({req, " linear"}, {co_l, sum_l}, ref_add(x, y, c));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {co_s, sum_s}, 17'd0);
    run(16'h0000, 16'h0000, 1'b1, "R4 cin only");
    run(16'hffff, 16'h0000, 1'b1, "R5 wrap");
    run(16'hffff, 16'hffff, 1'b1, "R7 max");
    run(16'h8000, 16'h8000, 1'b0, "R7 top carry");
    // Carry created just below each square-root boundary (2,4,7,11).
    foreach (dut_bounds[i]) run(16'((17'd1 << dut_bounds[i]) - 1), 16'h0001, 1'b0, "R2 boundary");
    foreach (dut_bounds[i]) run(16'((17'd1 << dut_bounds[i]) - 2), 16'h0000, 1'b1, "R2 boundary cin");
    // Linear boundaries (4,8,12).
    for (int k = 4; k < 16; k += 4) run(16'((17'd1 << k) - 1), 16'h0001, 1'b0, "R3 boundary");
    run(16'h5555, 16'haaaa, 1'b1, "R6 full propagate");
    run(16'h1234, 16'h4321, 1'b0, "R1 plain");
    for (int n = 0; n < 3000; n++)
      run(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    for (int n = 0; n < 200; n++) begin
      logic [15:0] x;
      x = 16'($urandom);
      run(x, ~x, 1'($urandom), "R6 random propagate");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int dut_bounds[4] = '{2, 4, 7, 11};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule